// File: doc/BRIEF.md
# Ethernet DMA Status and Interrupt Register Slice

This block holds the status words of an Ethernet MAC's transmit and receive DMA engines, an interrupt mask, a masked interrupt vector, a FIFO-enable handshake word and the two descriptor pointers. Software reaches it through a word-addressed register port with separate read and write strobes. The DMA engines reach it through single-cycle event pulses: packet completed, transmit underrun and receive overflow. One level-sensitive interrupt line leaves the block.

Each direction counts its completed packets in an 8-bit counter. Software acknowledges one packet at a time by writing a one to the packet-done flag, which decrements the counter. The flag falls only when the count reaches zero, so a driver that services packets one per acknowledge never loses a completion that landed while it was busy.

Word offsets: 0 transmit status, 1 receive status, 2 interrupt mask, 3 interrupt vector, 4 FIFO configuration, 5 transmit descriptor pointer, 6 receive descriptor pointer, 7 unused.

Top module: `dma_status_regs`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: A packet-done pulse increments that direction's count in status bits [23:16] and sets the done flag in bit 0.
- R3: A status write with bit 0 set decrements the count; bit 0 clears only if the new count is zero, otherwise it stays set.
- R4: A packet-done pulse and a decrementing write in the same cycle leave the count unchanged and bit 0 set; the count wraps modulo 256 (255 plus one gives 0, with bit 0 set).
- R5: The underrun pulse sets transmit status bit 1 and the overflow pulse sets receive status bit 2; a write of 1 to that bit clears it, and a pulse in the same cycle as the clearing write wins.
- R6: Offset 3 reads mask[7:0] ANDed with {receive status[3:0], transmit status[3:0]}, receive in bits [7:4]; writes to offset 3 have no effect.
- R7: `irq` is high exactly when the masked vector of R6 is non-zero, in the cycle after the state change.
- R8: A write to the FIFO configuration word stores the data as written except that bits [20:16] take the value of written bits [12:8]; a later write with a request bit cleared clears its reply bit.
- R9: A write to either descriptor pointer stores the data with bits [1:0] forced to zero.
- R10: The mask register keeps only bits [7:0]; bits [31:8] read zero.
- R11: `reg_rdata` is updated one cycle after `reg_rd` with the register value from before any write in that same cycle. Offset 7 reads zero, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Word offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| tx_pkt_done | input | 1 | Transmit packet completed pulse |
| tx_underrun | input | 1 | Transmit underrun pulse |
| rx_pkt_done | input | 1 | Receive packet completed pulse |
| rx_overflow | input | 1 | Receive overflow pulse |
| irq | output | 1 | Level interrupt |

## Verification
The checker assumes that event inputs are one-cycle pulses sampled on the rising edge. It also assumes that a write strobe carries one offset at a time, so no decrement and no clear can reach a counter or flag from any path other than the decoded write. The bench changes inputs only on falling edges and drives at most one register access per cycle. It places completion pulses and acknowledges in the same cycle on purpose, and it pushes the receive count past 255, so the net-zero and wrap rules are both exercised under these conditions.

// File: rtl/dmastat_pkg.sv
package dmastat_pkg;
    localparam int NDIR      = 2;
    localparam int OFF_TXST  = 0;
    localparam int OFF_RXST  = 1;
    localparam int OFF_MASK  = 2;
    localparam int OFF_IVEC  = 3;
    localparam int OFF_FIFO  = 4;
    localparam int OFF_TXPTR = 5;
    localparam int OFF_RXPTR = 6;
    localparam int ERR_BIT_TX = 1;
    localparam int ERR_BIT_RX = 2;
endpackage

// File: rtl/dmastat_word.sv
module dmastat_word #(
    parameter int WORD_W  = 32,
    parameter int CNT_W   = 8,
    parameter int CNT_LSB = 16,
    parameter int ERR_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_evt,
    input  logic              err_evt,
    input  logic              dec_req,
    input  logic              clr_req,
    output logic [WORD_W-1:0] word
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             err;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case ({pkt_evt, dec_req})
            2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
        if (pkt_evt)
            st_d.done = 1'b1;
        else if (dec_req && st_d.cnt == '0)
            st_d.done = 1'b0;
        if (err_evt)
            st_d.err = 1'b1;
        else if (clr_req)
            st_d.err = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        word = '0;
        word[CNT_LSB +: CNT_W] = st_q.cnt;
        word[0]                = st_q.done;
        word[ERR_BIT]          = st_q.err;
    end
endmodule

// File: rtl/dmastat_ctrl_regs.sv
module dmastat_ctrl_regs #(
    parameter int WORD_W  = 32,
    parameter int MASK_W  = 8,
    parameter int ENA_W   = 5,
    parameter int REQ_LSB = 8,
    parameter int RPL_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_mask,
    input  logic              wr_fifo,
    input  logic              wr_txp,
    input  logic              wr_rxp,
    input  logic [WORD_W-1:0] wdata,
    output logic [MASK_W-1:0] mask,
    output logic [WORD_W-1:0] fifo,
    output logic [WORD_W-1:0] txp,
    output logic [WORD_W-1:0] rxp
);
    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic [WORD_W-1:0] fifo;
        logic [WORD_W-1:0] txp;
        logic [WORD_W-1:0] rxp;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [WORD_W-1:0] aligned;
    logic [WORD_W-1:0] fifo_img;

    always_comb begin
        aligned  = {wdata[WORD_W-1:2], 2'b00};
        fifo_img = wdata;
        fifo_img[RPL_LSB +: ENA_W] = wdata[REQ_LSB +: ENA_W];
        ctl_d = ctl_q;
        if (wr_mask) ctl_d.mask = wdata[MASK_W-1:0];
        if (wr_fifo) ctl_d.fifo = fifo_img;
        if (wr_txp)  ctl_d.txp  = aligned;
        if (wr_rxp)  ctl_d.rxp  = aligned;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign mask = ctl_q.mask;
    assign fifo = ctl_q.fifo;
    assign txp  = ctl_q.txp;
    assign rxp  = ctl_q.rxp;
endmodule

// File: rtl/dmastat_irq.sv
module dmastat_irq #(
    parameter int LOW_W = 4
) (
    input  logic [LOW_W-1:0]   tx_low,
    input  logic [LOW_W-1:0]   rx_low,
    input  logic [2*LOW_W-1:0] mask,
    output logic [2*LOW_W-1:0] vec,
    output logic               line
);
    assign vec  = mask & {rx_low, tx_low};
    assign line = |vec;
endmodule

// File: rtl/dma_status_regs.sv
module dma_status_regs #(
    parameter int ADDR_W  = 3,
    parameter int WORD_W  = 32,
    parameter int CNT_W   = 8,
    parameter int CNT_LSB = 16,
    parameter int LOW_W   = 4,
    parameter int ENA_W   = 5,
    parameter int REQ_LSB = 8,
    parameter int RPL_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              tx_pkt_done,
    input  logic              tx_underrun,
    input  logic              rx_pkt_done,
    input  logic              rx_overflow,
    output logic              irq
);
    import dmastat_pkg::*;

    localparam int MASK_W = 2 * LOW_W;

    logic [NDIR-1:0]   pkt_evt, err_evt, st_wr;
    logic [WORD_W-1:0] stat_word [NDIR];
    logic [MASK_W-1:0] mask_q, ivec;
    logic [WORD_W-1:0] fifo_q, txp_q, rxp_q;

    assign pkt_evt = {rx_pkt_done, tx_pkt_done};
    assign err_evt = {rx_overflow, tx_underrun};
    assign st_wr   = {reg_wr && reg_addr == ADDR_W'(OFF_RXST),
                      reg_wr && reg_addr == ADDR_W'(OFF_TXST)};

    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        localparam int EB = (g == 0) ? ERR_BIT_TX : ERR_BIT_RX;
        dmastat_word #(
            .WORD_W(WORD_W), .CNT_W(CNT_W), .CNT_LSB(CNT_LSB), .ERR_BIT(EB)
        ) u_word (
            .clk     (clk),
            .rst_n   (rst_n),
            .pkt_evt (pkt_evt[g]),
            .err_evt (err_evt[g]),
            .dec_req (st_wr[g] && reg_wdata[0]),
            .clr_req (st_wr[g] && reg_wdata[EB]),
            .word    (stat_word[g])
        );
    end

    dmastat_ctrl_regs #(
        .WORD_W(WORD_W), .MASK_W(MASK_W), .ENA_W(ENA_W),
        .REQ_LSB(REQ_LSB), .RPL_LSB(RPL_LSB)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mask (reg_wr && reg_addr == ADDR_W'(OFF_MASK)),
        .wr_fifo (reg_wr && reg_addr == ADDR_W'(OFF_FIFO)),
        .wr_txp  (reg_wr && reg_addr == ADDR_W'(OFF_TXPTR)),
        .wr_rxp  (reg_wr && reg_addr == ADDR_W'(OFF_RXPTR)),
        .wdata   (reg_wdata),
        .mask    (mask_q),
        .fifo    (fifo_q),
        .txp     (txp_q),
        .rxp     (rxp_q)
    );

    dmastat_irq #(.LOW_W(LOW_W)) u_irq (
        .tx_low (stat_word[0][LOW_W-1:0]),
        .rx_low (stat_word[1][LOW_W-1:0]),
        .mask   (mask_q),
        .vec    (ivec),
        .line   (irq)
    );

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (reg_rd) begin
            case (reg_addr)
                ADDR_W'(OFF_TXST):  rd_d.rdata = stat_word[0];
                ADDR_W'(OFF_RXST):  rd_d.rdata = stat_word[1];
                ADDR_W'(OFF_MASK):  rd_d.rdata = WORD_W'(mask_q);
                ADDR_W'(OFF_IVEC):  rd_d.rdata = WORD_W'(ivec);
                ADDR_W'(OFF_FIFO):  rd_d.rdata = fifo_q;
                ADDR_W'(OFF_TXPTR): rd_d.rdata = txp_q;
                ADDR_W'(OFF_RXPTR): rd_d.rdata = rxp_q;
                default:            rd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign reg_rdata = rd_q.rdata;
endmodule

// File: rtl/dma_status_regs_chk.sv
module dma_status_regs_chk #(
    parameter int CNT_W  = 8,
    parameter int MASK_W = 8,
    parameter int ENA_W  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_tx,
    input logic             wd_done,
    input logic             wd_err,
    input logic             tx_pkt_done,
    input logic             tx_underrun,
    input logic [CNT_W-1:0] tx_cnt,
    input logic             tx_done,
    input logic             tx_err,
    input logic [MASK_W-1:0] mask,
    input logic [ENA_W-1:0] fifo_rpl,
    input logic [ENA_W-1:0] fifo_req,
    input logic [1:0]       txp_lo,
    input logic             irq
);
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pkt_done && !(wr_tx && wd_done)) |=> tx_cnt == $past(tx_cnt) + CNT_W'(1)); // R2
    AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pkt_done |=> tx_done); // R2
    AST_CNT_NET: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pkt_done && wr_tx && wd_done) |=> $stable(tx_cnt)); // R4
    AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underrun |=> tx_err); // R5
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_err && !(wr_tx && wd_err)) |=> tx_err); // R5
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq); // R7
    AST_FIFO_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rpl == fifo_req); // R8
    AST_PTR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        txp_lo == 2'b00); // R9
endmodule

bind dma_status_regs dma_status_regs_chk #(
    .CNT_W(CNT_W), .MASK_W(2 * LOW_W), .ENA_W(ENA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_tx       (st_wr[0]),
    .wd_done     (reg_wdata[0]),
    .wd_err      (reg_wdata[1]),
    .tx_pkt_done (tx_pkt_done),
    .tx_underrun (tx_underrun),
    .tx_cnt      (stat_word[0][CNT_LSB +: CNT_W]),
    .tx_done     (stat_word[0][0]),
    .tx_err      (stat_word[0][1]),
    .mask        (mask_q),
    .fifo_rpl    (fifo_q[RPL_LSB +: ENA_W]),
    .fifo_req    (fifo_q[REQ_LSB +: ENA_W]),
    .txp_lo      (txp_q[1:0]),
    .irq         (irq)
);

// File: tb/dma_status_regs_test.sv
`timescale 1ns/1ps
module dma_status_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_pkt_done = 1'b0, tx_underrun = 1'b0;
    logic        rx_pkt_done = 1'b0, rx_overflow = 1'b0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done_run = 1'b0;

    always #2 clk = ~clk;

    dma_status_regs uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_pkt_done(tx_pkt_done), .tx_underrun(tx_underrun),
        .rx_pkt_done(rx_pkt_done), .rx_overflow(rx_overflow), .irq(irq)
    );

    // behavioural reference model
    logic [7:0]  m_txc = '0, m_rxc = '0, m_mask = '0;
    bit          m_txd = 0, m_txu = 0, m_rxd = 0, m_rxo = 0;
    logic [31:0] m_fifo = '0, m_txp = '0, m_rxp = '0;
    logic [31:0] m_exp_rd = '0;
    bit          m_rd_pend = 0;

    function automatic logic [31:0] m_tx();
        return {8'h0, m_txc, 14'h0, m_txu, m_txd};
    endfunction
    function automatic logic [31:0] m_rx();
        return {8'h0, m_rxc, 13'h0, m_rxo, 1'b0, m_rxd};
    endfunction
    function automatic logic [7:0] m_vec();
        return m_mask & {m_rx()[3:0], m_tx()[3:0]};
    endfunction
    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_tx();
            3'd1: return m_rx();
            3'd2: return {24'h0, m_mask};
            3'd3: return {24'h0, m_vec()};
            3'd4: return m_fifo;
            3'd5: return m_txp;
            3'd6: return m_rxp;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst_n) begin
            bit tdec, rdec;
            if (reg_rd) begin
                m_exp_rd  = m_read(reg_addr);
                m_rd_pend = 1;
            end
            tdec = reg_wr && reg_addr == 3'd0 && reg_wdata[0];
            rdec = reg_wr && reg_addr == 3'd1 && reg_wdata[0];
            m_txc = m_txc + 8'(tx_pkt_done) - 8'(tdec);
            m_rxc = m_rxc + 8'(rx_pkt_done) - 8'(rdec);
            if (tx_pkt_done) m_txd = 1; else if (tdec && m_txc == 0) m_txd = 0;
            if (rx_pkt_done) m_rxd = 1; else if (rdec && m_rxc == 0) m_rxd = 0;
            if (tx_underrun) m_txu = 1;
            else if (reg_wr && reg_addr == 3'd0 && reg_wdata[1]) m_txu = 0;
            if (rx_overflow) m_rxo = 1;
            else if (reg_wr && reg_addr == 3'd1 && reg_wdata[2]) m_rxo = 0;
            if (reg_wr) begin
                case (reg_addr)
                    3'd2: m_mask = reg_wdata[7:0];
                    3'd4: m_fifo = {reg_wdata[31:21], reg_wdata[12:8], reg_wdata[15:0]};
                    3'd5: m_txp = reg_wdata & 32'hFFFF_FFFC;
                    3'd6: m_rxp = reg_wdata & 32'hFFFF_FFFC;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison with the model
    always @(negedge clk) begin
        if (rst_n && !done_run) begin
            chk({31'h0, irq}, {31'h0, |m_vec()}, "R7 model irq");
            if (m_rd_pend) begin
                chk(reg_rdata, m_exp_rd, "R11 model rdata");
                m_rd_pend = 0;
            end
        end
    end

    task automatic cyc(input bit wr, input bit rd, input logic [2:0] a, input logic [31:0] d,
                       input bit td, input bit tu, input bit rd_, input bit ro);
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
        tx_pkt_done = td; tx_underrun = tu; rx_pkt_done = rd_; rx_overflow = ro;
        @(negedge clk);
        reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
        tx_pkt_done = 0; tx_underrun = 0; rx_pkt_done = 0; rx_overflow = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cyc(1, 0, a, d, 0, 0, 0, 0);
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        cyc(0, 1, a, 32'h0, 0, 0, 0, 0);
        chk(reg_rdata, exp, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk({31'h0, irq}, 32'h0, "R1 irq after reset");
        for (int a = 0; a < 7; a++) rd(3'(a), 32'h0, "R1 reset value");

        repeat (3) cyc(0, 0, 3'd0, 0, 1, 0, 0, 0);
        rd(3'd0, 32'h0003_0001, "R2 tx count 3");
        cyc(0, 0, 3'd0, 0, 0, 0, 1, 0);
        rd(3'd1, 32'h0001_0001, "R2 rx count 1");

        wr(3'd0, 32'h1);
        rd(3'd0, 32'h0002_0001, "R3 tx dec keeps flag");
        wr(3'd0, 32'h1);
        wr(3'd0, 32'h1);
        rd(3'd0, 32'h0000_0000, "R3 tx flag clears at zero");

        cyc(1, 0, 3'd1, 32'h1, 0, 0, 1, 0);
        rd(3'd1, 32'h0001_0001, "R4 simultaneous inc and dec");
        for (int i = 0; i < 255; i++) cyc(0, 0, 3'd0, 0, 0, 0, 1, 0);
        rd(3'd1, 32'h0000_0001, "R4 count wraps to zero");

        cyc(0, 0, 3'd0, 0, 0, 1, 0, 0);
        rd(3'd0, 32'h0000_0002, "R5 underrun set");
        wr(3'd2, 32'h2);
        chk({31'h0, irq}, 32'h1, "R7 irq on masked underrun");
        rd(3'd3, 32'h0000_0002, "R6 vector tx bit");
        wr(3'd0, 32'h2);
        rd(3'd0, 32'h0000_0000, "R5 underrun cleared");
        chk({31'h0, irq}, 32'h0, "R7 irq drops");

        cyc(0, 0, 3'd0, 0, 0, 0, 0, 1);
        rd(3'd1, 32'h0000_0005, "R5 overflow set");
        wr(3'd2, 32'hFF);
        rd(3'd3, 32'h0000_0050, "R6 vector rx half");
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, 32'h0000_0050, "R6 vector write ignored");
        cyc(1, 0, 3'd1, 32'h4, 0, 0, 0, 1);
        rd(3'd1, 32'h0000_0005, "R5 event beats clear");
        wr(3'd1, 32'h4);
        rd(3'd1, 32'h0000_0001, "R5 overflow cleared");
        chk({31'h0, irq}, 32'h1, "R7 irq from rx done flag");

        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, 32'h0000_00FF, "R10 mask width");

        wr(3'd4, 32'h001F_1500);
        rd(3'd4, 32'h0015_1500, "R8 reply mirrors request");
        wr(3'd4, 32'h0000_0003);
        rd(3'd4, 32'h0000_0003, "R8 reply clears with request");

        wr(3'd5, 32'h1234_5677);
        rd(3'd5, 32'h1234_5674, "R9 tx pointer aligned");
        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd6, 32'hFFFF_FFFC, "R9 rx pointer aligned");

        wr(3'd7, 32'hDEAD_BEEF);
        rd(3'd7, 32'h0, "R11 unused offset");
        cyc(1, 1, 3'd2, 32'h0F, 0, 0, 0, 0);
        chk(reg_rdata, 32'h0000_00FF, "R11 read sees old value");
        rd(3'd2, 32'h0000_000F, "R11 write landed");

        repeat (2) @(negedge clk);
        done_run = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        done_run = 1'b1;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule